// File: doc/BRIEF.md
# Command Parser Interrupt Controller

This block gathers the interrupt causes of a graphics command parser and its display engine into a single interrupt line. Five sources are handled: the breakpoint packet, the user-defined interrupt packet, a display sub-event summary, the start of vertical blanking, and overlay flip completion. Each source latches a sticky bit in an identity register. Software clears a bit by writing one to it. An interrupt mask register decides which latched bits drive the interrupt output. A separate hardware-status mask decides whether a breakpoint packet asks for a store-dword cycle.

Flips use two opposite views. The status register shows a flip as pending from the moment its packet is parsed until the next blanking period applies it. The identity bit latches only when the flip completes. The leading edge of blanking starts a small sequencer with the states IDLE, UPDATE and WAIT. On IDLE to UPDATE the edge is taken. UPDATE applies the flip and updates status. UPDATE to WAIT always follows. WAIT counts down and, on WAIT to IDLE, posts the blanking identity bit. This order means software sees the blanking cause only after the overlay and status updates are done.

A breakpoint that is unmasked in both masks stalls the parser. A two-state machine moves from RUN to HALT when such a breakpoint arrives. It moves from HALT back to RUN in the cycle that software clears the breakpoint identity bit.

Top module: `gcp_irq_ctrl`

## Requirements
- R1: After reset, the identity, status and display-enable registers read 0. The interrupt mask and hardware-status mask read 0x02C3, which is every implemented bit set. halt_o, store_req_o, flip_pend_o and irq_o are 0.
- R2: A flip_parsed_i pulse sets flip_pend_o and status bit 9 (register address 4) at the next clock edge.
- R3: The leading edge of vblank_i is sampled at edge k. At edge k+1 a pending flip is cleared and identity bit 9 is set. If no flip is pending, bit 9 is not set. A flip_parsed_i in that same cycle leaves the flip pending.
- R4: Identity bit 7 is set at edge k+VBL_DELAY (default 4), after the flip update. Leading edges that arrive while the sequencer is busy are ignored.
- R5: Identity bit 6 latches when the OR of (disp_evt_i AND the display-enable register at address 3) rises. Status bit 6 reads the live value of that OR.
- R6: A user_irq_i pulse sets identity bit 1.
- R7: A brk_pkt_i pulse sets identity bit 0. store_req_o is high for one cycle after the pulse only if hardware-status mask bit 0 is 0.
- R8: halt_o rises after a brk_pkt_i only when bit 0 is 0 in both the interrupt mask and the hardware-status mask. It stays high until the breakpoint identity bit is cleared, and it falls at the same edge as that clear.
- R9: A write to address 0 clears every identity bit written as 1. When a set and a clear of the same bit fall in the same cycle, the bit stays set.
- R10: irq_o is 1 exactly when some identity bit is 1 and its interrupt mask bit (address 1, 1 = masked) is 0.
- R11: Reserved bits 2 to 5 and 8 are ignored on write and read as 0 in every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flip_parsed_i | input | 1 | Flip packet parsed (pulse) |
| user_irq_i | input | 1 | User-defined interrupt packet (pulse) |
| brk_pkt_i | input | 1 | Breakpoint packet (pulse) |
| vblank_i | input | 1 | Display vertical blanking level |
| disp_evt_i | input | NEVT | Display sub-events: hot-plug, vsync, line compare |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address: 0 identity, 1 irq mask, 2 hw-status mask, 3 event enable, 4 status |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Interrupt line |
| store_req_o | output | 1 | Store-dword request pulse |
| halt_o | output | 1 | Parser halt |
| flip_pend_o | output | 1 | Flip pending status |

## Verification
Two pairs of events can land in the same cycle. The first pair is a new flip packet arriving in the UPDATE cycle that completes the previous flip. The second is a software clear of an identity bit that coincides with a fresh set of that bit. The bench forces both by driving the packet pulse in the cycle after the blanking edge, and by driving the write strobe together with the source pulse. Correct behaviour is judged from the results: the flip stays pending while bit 9 latches, and the identity bit stays set. A behavioural model that steps on every clock checks these results, and directed reads confirm the register values.

// File: rtl/gcp_irq_pkg.sv
package gcp_irq_pkg;
    localparam int REG_W = 16;
    localparam int B_BRK = 0;
    localparam int B_USR = 1;
    localparam int B_EVT = 6;
    localparam int B_VBL = 7;
    localparam int B_FLIP = 9;
    localparam logic [REG_W-1:0] IMPL_MASK = 16'h02C3;

    typedef enum logic [2:0] {
        A_ID   = 3'd0,
        A_IMR  = 3'd1,
        A_HWSM = 3'd2,
        A_EVEN = 3'd3,
        A_STAT = 3'd4
    } addr_e;

    typedef enum logic [1:0] {
        V_IDLE,
        V_UPD,
        V_WAIT
    } vbl_st_e;

    typedef enum logic {
        H_RUN,
        H_HALT
    } halt_st_e;
endpackage

// File: rtl/gcp_vbl_seq.sv
module gcp_vbl_seq
    import gcp_irq_pkg::*;
#(
    parameter int DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vblank_i,
    output logic upd_o,
    output logic fire_o
);
    localparam int CW = (DELAY > 2) ? $clog2(DELAY) : 1;

    vbl_st_e        st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           vb_q;
    logic           rise;

    assign rise = vblank_i & ~vb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= V_IDLE;
            cnt_q <= '0;
            vb_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            vb_q  <= vblank_i;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            V_IDLE: if (rise) begin
                st_d  = V_UPD;
                cnt_d = CW'(DELAY - 1);
            end
            V_UPD: begin
                st_d  = V_WAIT;
                cnt_d = cnt_q - 1'b1;
            end
            V_WAIT: begin
                if (cnt_q == '0) st_d = V_IDLE;
                else             cnt_d = cnt_q - 1'b1;
            end
            default: st_d = V_IDLE;
        endcase
    end

    always_comb begin
        upd_o  = (st_q == V_UPD);
        fire_o = (st_q == V_WAIT) && (cnt_q == '0);
    end
endmodule

// File: rtl/gcp_evt_detect.sv
module gcp_evt_detect #(
    parameter int NEVT = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEVT-1:0] evt_i,
    input  logic [NEVT-1:0] en_i,
    output logic            or_o,
    output logic            rise_o
);
    logic or_q;

    assign or_o   = |(evt_i & en_i);
    assign rise_o = or_o & ~or_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) or_q <= 1'b0;
        else        or_q <= or_o;
    end
endmodule

// File: rtl/gcp_halt_fsm.sv
module gcp_halt_fsm
    import gcp_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic brk_i,
    input  logic hw_unmask_i,
    input  logic irq_unmask_i,
    input  logic id_next_i,
    output logic halt_o
);
    halt_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= H_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            H_RUN:  if (brk_i && hw_unmask_i && irq_unmask_i) st_d = H_HALT;
            H_HALT: if (!id_next_i) st_d = H_RUN;
            default: st_d = H_RUN;
        endcase
    end

    always_comb halt_o = (st_q == H_HALT);
endmodule

// File: rtl/gcp_irq_ctrl.sv
module gcp_irq_ctrl
    import gcp_irq_pkg::*;
#(
    parameter int NEVT      = 3,
    parameter int VBL_DELAY = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flip_parsed_i,
    input  logic            user_irq_i,
    input  logic            brk_pkt_i,
    input  logic            vblank_i,
    input  logic [NEVT-1:0] disp_evt_i,
    input  logic            reg_wr_i,
    input  logic [2:0]      reg_addr_i,
    input  logic [15:0]     reg_wdata_i,
    output logic [15:0]     reg_rdata_o,
    output logic            irq_o,
    output logic            store_req_o,
    output logic            halt_o,
    output logic            flip_pend_o
);
    logic [REG_W-1:0] id_q, id_d, id_set, id_clr;
    logic [REG_W-1:0] imr_q, hwsm_q;
    logic [NEVT-1:0]  en_q;
    logic             pend_q;
    logic             upd, fire, evt_or, evt_rise;

    gcp_vbl_seq #(.DELAY(VBL_DELAY)) u_vbl (
        .clk(clk), .rst_n(rst_n), .vblank_i(vblank_i),
        .upd_o(upd), .fire_o(fire)
    );

    gcp_evt_detect #(.NEVT(NEVT)) u_evt (
        .clk(clk), .rst_n(rst_n), .evt_i(disp_evt_i), .en_i(en_q),
        .or_o(evt_or), .rise_o(evt_rise)
    );

    gcp_halt_fsm u_halt (
        .clk(clk), .rst_n(rst_n), .brk_i(brk_pkt_i),
        .hw_unmask_i(~hwsm_q[B_BRK]), .irq_unmask_i(~imr_q[B_BRK]),
        .id_next_i(id_d[B_BRK]), .halt_o(halt_o)
    );

    always_comb begin
        id_set         = '0;
        id_set[B_BRK]  = brk_pkt_i;
        id_set[B_USR]  = user_irq_i;
        id_set[B_EVT]  = evt_rise;
        id_set[B_VBL]  = fire;
        id_set[B_FLIP] = upd & pend_q;
        id_clr = (reg_wr_i && reg_addr_i == A_ID) ? (reg_wdata_i & IMPL_MASK) : '0;
        id_d   = (id_q & ~id_clr) | id_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q        <= '0;
            imr_q       <= IMPL_MASK;
            hwsm_q      <= IMPL_MASK;
            en_q        <= '0;
            pend_q      <= 1'b0;
            store_req_o <= 1'b0;
        end else begin
            id_q        <= id_d;
            pend_q      <= flip_parsed_i | (pend_q & ~upd);
            store_req_o <= brk_pkt_i & ~hwsm_q[B_BRK];
            if (reg_wr_i && reg_addr_i == A_IMR)  imr_q  <= reg_wdata_i & IMPL_MASK;
            if (reg_wr_i && reg_addr_i == A_HWSM) hwsm_q <= reg_wdata_i & IMPL_MASK;
            if (reg_wr_i && reg_addr_i == A_EVEN) en_q   <= reg_wdata_i[NEVT-1:0];
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            A_ID:   reg_rdata_o = id_q;
            A_IMR:  reg_rdata_o = imr_q;
            A_HWSM: reg_rdata_o = hwsm_q;
            A_EVEN: reg_rdata_o = {{(REG_W-NEVT){1'b0}}, en_q};
            A_STAT: begin
                reg_rdata_o[B_FLIP] = pend_q;
                reg_rdata_o[B_EVT]  = evt_or;
            end
            default: reg_rdata_o = '0;
        endcase
    end

    assign irq_o       = |(id_q & ~imr_q);
    assign flip_pend_o = pend_q;
endmodule

// File: rtl/gcp_irq_ctrl_chk.sv
module gcp_irq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        flip_parsed_i,
    input logic        brk_pkt_i,
    input logic        reg_wr_i,
    input logic [2:0]  reg_addr_i,
    input logic [15:0] id_q,
    input logic [15:0] imr_q,
    input logic [15:0] hwsm_q,
    input logic        halt_o,
    input logic        store_req_o,
    input logic        flip_pend_o
);
    p_pend_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flip_parsed_i |=> flip_pend_o);

    p_flip_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_q[9]) |-> $past(flip_pend_o));

    p_store_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pkt_i && !hwsm_q[0]) |=> store_req_o);

    p_store_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(brk_pkt_i && !hwsm_q[0]) |=> !store_req_o);

    p_halt_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pkt_i && !hwsm_q[0] && !imr_q[0]) |=> halt_o);

    p_halt_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halt_o) |-> !id_q[0]);

    p_id_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_addr_i == 3'd0) |=> ((id_q & $past(id_q)) == $past(id_q)));
endmodule

bind gcp_irq_ctrl gcp_irq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .flip_parsed_i(flip_parsed_i), .brk_pkt_i(brk_pkt_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .id_q(id_q), .imr_q(imr_q),
    .hwsm_q(hwsm_q), .halt_o(halt_o), .store_req_o(store_req_o), .flip_pend_o(flip_pend_o)
);

// File: tb/test_gcp_irq_ctrl.sv
module test_gcp_irq_ctrl;
    localparam int NEVT = 3;
    localparam int D    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flip_parsed_i = 0, user_irq_i = 0, brk_pkt_i = 0, vblank_i = 0;
    logic [NEVT-1:0] disp_evt_i = '0;
    logic reg_wr_i = 0;
    logic [2:0] reg_addr_i = 3'd0;
    logic [15:0] reg_wdata_i = 16'h0;
    logic [15:0] reg_rdata_o;
    logic irq_o, store_req_o, halt_o, flip_pend_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur = "R1";

    always #4 clk = ~clk;

    gcp_irq_ctrl #(.NEVT(NEVT), .VBL_DELAY(D)) i_gcp_irq_ctrl (.*);

    // behavioural reference model
    logic [15:0] m_id, m_imr, m_hwsm;
    logic [NEVT-1:0] m_en;
    logic m_pend, m_store, m_halt, m_vbq, m_evtq;
    int m_vage;

    always @(posedge clk or negedge rst_n) begin
        logic [15:0] s, clr, nid;
        logic eo, upd, fire;
        if (!rst_n) begin
            m_id = 0; m_imr = 16'h02C3; m_hwsm = 16'h02C3; m_en = 0;
            m_pend = 0; m_store = 0; m_halt = 0; m_vbq = 0; m_evtq = 0; m_vage = 0;
        end else begin
            eo   = |(disp_evt_i & m_en);
            upd  = (m_vage == 1);
            fire = (m_vage == D);
            s = 0;
            if (brk_pkt_i) s[0] = 1;
            if (user_irq_i) s[1] = 1;
            if (eo && !m_evtq) s[6] = 1;
            if (fire) s[7] = 1;
            if (upd && m_pend) s[9] = 1;
            clr = (reg_wr_i && reg_addr_i == 0) ? (reg_wdata_i & 16'h02C3) : 16'h0;
            nid = (m_id & ~clr) | s;
            m_store = brk_pkt_i && !m_hwsm[0];
            if (!m_halt) m_halt = brk_pkt_i && !m_hwsm[0] && !m_imr[0];
            else if (!nid[0]) m_halt = 0;
            m_pend = flip_parsed_i || (m_pend && !upd);
            if (m_vage == 0) begin
                if (vblank_i && !m_vbq) m_vage = 1;
            end else if (m_vage == D) m_vage = 0;
            else m_vage = m_vage + 1;
            m_vbq = vblank_i;
            m_evtq = eo;
            if (reg_wr_i && reg_addr_i == 1) m_imr = reg_wdata_i & 16'h02C3;
            if (reg_wr_i && reg_addr_i == 2) m_hwsm = reg_wdata_i & 16'h02C3;
            if (reg_wr_i && reg_addr_i == 3) m_en = reg_wdata_i[NEVT-1:0];
            m_id = nid;
        end
    end

    function automatic logic [15:0] m_rd(input logic [2:0] a);
        logic [15:0] r = 0;
        case (a)
            3'd0: r = m_id;
            3'd1: r = m_imr;
            3'd2: r = m_hwsm;
            3'd3: r = {{(16-NEVT){1'b0}}, m_en};
            3'd4: begin r[9] = m_pend; r[6] = |(disp_evt_i & m_en); end
            default: r = 0;
        endcase
        return r;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({cur, " irq_o (R10)"}, 16'(irq_o), 16'(|(m_id & ~m_imr)));
            chk({cur, " store_req_o (R7)"}, 16'(store_req_o), 16'(m_store));
            chk({cur, " halt_o (R8)"}, 16'(halt_o), 16'(m_halt));
            chk({cur, " flip_pend_o (R2)"}, 16'(flip_pend_o), 16'(m_pend));
            chk({cur, " rdata"}, reg_rdata_o, m_rd(reg_addr_i));
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
        step(1);
        reg_wr_i = 0;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [15:0] exp);
        reg_addr_i = a;
        #1;
        chk(tag, reg_rdata_o, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        cur = "R1";
        rd("R1 id", 3'd0, 16'h0000);
        rd("R1 imr", 3'd1, 16'h02C3);
        rd("R1 hwsm", 3'd2, 16'h02C3);
        rd("R1 en", 3'd3, 16'h0000);
        rd("R1 stat", 3'd4, 16'h0000);
        chk("R1 halt_o", 16'(halt_o), 16'h0);

        cur = "R11";
        wr(3'd1, 16'hFFFF);
        rd("R11 imr reserved", 3'd1, 16'h02C3);
        wr(3'd1, 16'h0000);
        rd("R11 imr clear", 3'd1, 16'h0000);

        cur = "R6";
        user_irq_i = 1; step(1); user_irq_i = 0;
        rd("R6 id user", 3'd0, 16'h0002);
        chk("R10 irq unmasked", 16'(irq_o), 16'h1);

        cur = "R9";
        wr(3'd0, 16'h0002);
        rd("R9 w1c", 3'd0, 16'h0000);

        cur = "R10";
        wr(3'd1, 16'h0002);
        user_irq_i = 1; step(1); user_irq_i = 0;
        chk("R10 irq masked", 16'(irq_o), 16'h0);
        wr(3'd1, 16'h0000);
        chk("R10 irq unmask", 16'(irq_o), 16'h1);

        cur = "R9";
        user_irq_i = 1; reg_wr_i = 1; reg_addr_i = 3'd0; reg_wdata_i = 16'h0002;
        step(1);
        user_irq_i = 0; reg_wr_i = 0;
        rd("R9 set wins", 3'd0, 16'h0002);
        wr(3'd0, 16'hFFFF);

        cur = "R2";
        flip_parsed_i = 1; step(1); flip_parsed_i = 0;
        chk("R2 pend", 16'(flip_pend_o), 16'h1);
        rd("R2 stat", 3'd4, 16'h0200);

        cur = "R3";
        vblank_i = 1; step(1);
        chk("R3 pend before", 16'(flip_pend_o), 16'h1);
        step(1);
        chk("R3 pend cleared", 16'(flip_pend_o), 16'h0);
        rd("R3 id flip", 3'd0, 16'h0200);
        cur = "R4";
        step(2);
        rd("R4 no vbl yet", 3'd0, 16'h0200);
        vblank_i = 0;
        step(1);
        rd("R4 vbl bit", 3'd0, 16'h0280);
        wr(3'd0, 16'hFFFF);

        cur = "R3";
        flip_parsed_i = 1; step(1); flip_parsed_i = 0;
        vblank_i = 1; step(1);
        flip_parsed_i = 1; step(1); flip_parsed_i = 0;
        chk("R3 same-cycle stays pending", 16'(flip_pend_o), 16'h1);
        rd("R3 same-cycle id", 3'd0, 16'h0200);
        step(4); vblank_i = 0; step(2);
        wr(3'd0, 16'hFFFF);
        vblank_i = 1; step(6); vblank_i = 0;
        rd("R3 second flip done", 3'd0, 16'h0280);
        chk("R3 pend gone", 16'(flip_pend_o), 16'h0);
        wr(3'd0, 16'hFFFF);
        vblank_i = 1; step(6); vblank_i = 0;
        rd("R3 no pending no bit9", 3'd0, 16'h0080);
        wr(3'd0, 16'hFFFF);

        cur = "R4";
        vblank_i = 1; step(2); vblank_i = 0; step(1); vblank_i = 1; step(6); vblank_i = 0;
        rd("R4 busy edge ignored", 3'd0, 16'h0080);
        wr(3'd0, 16'hFFFF);

        cur = "R5";
        disp_evt_i = 3'b001; step(2);
        rd("R5 disabled", 3'd0, 16'h0000);
        rd("R5 stat disabled", 3'd4, 16'h0000);
        wr(3'd3, 16'h0001);
        rd("R5 stat live", 3'd4, 16'h0040);
        step(1);
        rd("R5 latched", 3'd0, 16'h0040);
        wr(3'd0, 16'h0040);
        disp_evt_i = 3'b011; step(2);
        rd("R5 no new edge", 3'd0, 16'h0000);
        disp_evt_i = 3'b000; step(1);
        disp_evt_i = 3'b100; step(1);
        rd("R5 masked source", 3'd0, 16'h0000);
        wr(3'd3, 16'h0007);
        step(1);
        rd("R5 all enabled", 3'd0, 16'h0040);
        disp_evt_i = 3'b000;
        wr(3'd0, 16'hFFFF);

        cur = "R7";
        wr(3'd2, 16'h0001);
        brk_pkt_i = 1; step(1); brk_pkt_i = 0;
        chk("R7 no store when masked", 16'(store_req_o), 16'h0);
        rd("R7 id brk", 3'd0, 16'h0001);
        chk("R8 no halt hw masked", 16'(halt_o), 16'h0);
        wr(3'd0, 16'h0001);
        wr(3'd2, 16'h0000);
        wr(3'd1, 16'h0001);
        brk_pkt_i = 1; step(1); brk_pkt_i = 0;
        chk("R7 store pulse", 16'(store_req_o), 16'h1);
        chk("R8 no halt irq masked", 16'(halt_o), 16'h0);
        step(1);
        chk("R7 store one cycle", 16'(store_req_o), 16'h0);
        wr(3'd0, 16'h0001);

        cur = "R8";
        wr(3'd1, 16'h0000);
        brk_pkt_i = 1; step(1); brk_pkt_i = 0;
        chk("R8 halt set", 16'(halt_o), 16'h1);
        step(3);
        chk("R8 halt held", 16'(halt_o), 16'h1);
        wr(3'd0, 16'h0002);
        chk("R8 other clear keeps halt", 16'(halt_o), 16'h1);
        wr(3'd0, 16'h0001);
        chk("R8 halt released", 16'(halt_o), 16'h0);
        step(3);
        finish_run();
    end
endmodule